// File: doc/BRIEF.md
# Five-State Cache Line Coherence Controller

This block tracks coherence state for the lines of a small direct-mapped write-back cache that sits behind a fully coherent master port. Each line is Invalid, UniqueClean, UniqueDirty, SharedClean or SharedDirty. Dirty marks the one holder that must eventually write the line back. SharedClean carries no such duty, even when its data differs from memory. Local load, store, eviction and eager-clean events are turned into the coherent request that fits what the cache already holds. The line state is updated when the interconnect reports completion.

Snoops arriving from the interconnect are answered one cycle later. The answer has four flags: data supplied, dirty responsibility passed, copy retained, and the line was unique. The snooped line moves to the state that the snoop type demands. A parameter selects whether the cache may hold lines in SharedDirty (the owned state). Without it, read misses ask for a line that never arrives shared-dirty, and a read-shared snoop hands dirty responsibility to the requester.

The data array, bus channel timing and the interconnect lie outside this block. The controller keeps one local request outstanding at a time.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `lcl_ready` is 1, and `lcl_done`, `req_valid` and `rsp_valid` are 0. The state codes are 0 Invalid, 1 UniqueClean, 2 UniqueDirty, 3 SharedClean, 4 SharedDirty.
- R2: A local event is accepted on a clock edge where `lcl_valid` and `lcl_ready` are both 1. In the following cycle `lcl_done` is 1. `lcl_prev_state` then gives the stored state of the addressed index, and `lcl_res` gives the result: 1 done locally, 2 request issued, 3 conflict, 4 nothing to do. Event codes are 0 load, 1 full-line store, 2 partial store, 3 evict, 4 eager clean. The low IDX_W address bits select the index and the rest form the tag.
- R3: A load that hits completes locally. A load miss issues read-shared (request code 1) when the owned state is enabled, and read-not-shared-dirty (code 2) when it is not. On completion the line becomes SharedDirty if shared, dirty and owned-enabled; SharedClean if shared; UniqueDirty if dirty; otherwise UniqueClean.
- R4: A store of either kind that hits a UniqueClean or UniqueDirty line completes locally with no request, and the line becomes UniqueDirty.
- R5: A full-line store that misses or hits a shared line issues make-unique (3). A partial store miss issues read-unique (4). A partial store that hits a shared line issues clean-unique (5). Each of these completes in UniqueDirty.
- R6: Evicting a dirty line issues write-back (6), and evicting a clean line issues evict (7). Both complete in Invalid. Evicting an address that is not held gives result 4 with no request.
- R7: An eager clean of a dirty line issues write-clean (8). On completion the line keeps its copy and goes from UniqueDirty to UniqueClean, or from SharedDirty to SharedClean. An eager clean of a clean or absent line gives result 4.
- R8: A load or store to an index that holds a valid line with a different tag gives result 3, issues no request and leaves the line unchanged.
- R9: `req_valid` pulses for one cycle with `req_type` and `req_addr`. From then until the edge where `cmp_valid` is taken, `lcl_ready` is 0. `lcl_ready` is also 0 in any cycle where `snp_valid` is 1.
- R10: Each snoop gets a response with `rsp_valid` one cycle after `snp_valid`. Snoop codes are 0 read-once, 1 read-shared, 2 read-unique, 3 clean-shared, 4 clean-invalid, 5 make-invalid. A snoop that misses returns all flags 0 and changes nothing. On a hit, `rsp_was_unique` is 1 exactly when the line was UniqueClean or UniqueDirty.
- R11: A read-once hit returns data with `rsp_is_shared` 1 and leaves the state unchanged. A read-shared hit returns data with `rsp_is_shared` 1 and moves a unique line to its shared form. A dirty line then either stays SharedDirty with `rsp_pass_dirty` 0 (owned state enabled), or becomes SharedClean with `rsp_pass_dirty` 1 (owned state disabled).
- R12: Read-unique, clean-invalid and make-invalid hits all end in Invalid with `rsp_is_shared` 0. Read-unique returns data, with `rsp_pass_dirty` equal to the dirty flag. Clean-invalid returns data and passes dirty only when the line was dirty. Make-invalid returns no data even for a dirty line.
- R13: A clean-shared hit returns data and passes dirty only when the line was dirty, sets `rsp_is_shared`, and moves the line to its clean counterpart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcl_valid | input | 1 | Local event present |
| lcl_op | input | 3 | Local event code |
| lcl_addr | input | ADDR_W | Line address of the local event |
| lcl_ready | output | 1 | Local event can be accepted this cycle |
| lcl_done | output | 1 | Result of the event accepted last cycle is valid |
| lcl_res | output | 3 | Local result code |
| lcl_prev_state | output | 3 | Stored state of the addressed index at acceptance |
| req_valid | output | 1 | Coherent request issued |
| req_type | output | 4 | Coherent request code |
| req_addr | output | ADDR_W | Line address of the request |
| cmp_valid | input | 1 | Outstanding request completed |
| cmp_shared | input | 1 | Completion: line is held elsewhere too |
| cmp_dirty | input | 1 | Completion: write-back duty handed over |
| snp_valid | input | 1 | Snoop present |
| snp_type | input | 3 | Snoop code |
| snp_addr | input | ADDR_W | Line address of the snoop |
| rsp_valid | output | 1 | Snoop response valid |
| rsp_data | output | 1 | Data supplied with the response |
| rsp_pass_dirty | output | 1 | Write-back duty passed to the requester |
| rsp_is_shared | output | 1 | Snooped cache keeps a copy |
| rsp_was_unique | output | 1 | Line was unique before the snoop |

## Verification
The bench builds two copies of the block with ADDR_W 6 and IDX_W 2, one with the owned state enabled and one without. Both copies receive the same stimulus. The sweep reaches every start state and applies every local event and every snoop type to each one. It reads the resulting state back through a following load, so every entry of the transition tables is covered for both variants. Directed cases cover tag conflicts on a shared index, snoop misses on a conflicting tag, and the completion flag combinations that separate the two variants on load misses.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [2:0] {
    ST_I  = 3'd0,
    ST_UC = 3'd1,
    ST_UD = 3'd2,
    ST_SC = 3'd3,
    ST_SD = 3'd4
  } line_st_e;

  typedef enum logic [2:0] {
    LOP_LOAD       = 3'd0,
    LOP_STORE_FULL = 3'd1,
    LOP_STORE_PART = 3'd2,
    LOP_EVICT      = 3'd3,
    LOP_CLEAN      = 3'd4
  } lcl_op_e;

  typedef enum logic [3:0] {
    RQ_NONE      = 4'd0,
    RQ_RD_SHARED = 4'd1,
    RQ_RD_NSD    = 4'd2,
    RQ_MAKE_UNIQ = 4'd3,
    RQ_RD_UNIQ   = 4'd4,
    RQ_CLN_UNIQ  = 4'd5,
    RQ_WR_BACK   = 4'd6,
    RQ_EVICT     = 4'd7,
    RQ_WR_CLEAN  = 4'd8
  } req_e;

  typedef enum logic [2:0] {
    SN_RD_ONCE    = 3'd0,
    SN_RD_SHARED  = 3'd1,
    SN_RD_UNIQ    = 3'd2,
    SN_CLN_SHARED = 3'd3,
    SN_CLN_INV    = 3'd4,
    SN_MK_INV     = 3'd5
  } snp_e;

  typedef enum logic [2:0] {
    LR_NONE     = 3'd0,
    LR_HIT      = 3'd1,
    LR_ISSUED   = 3'd2,
    LR_CONFLICT = 3'd3,
    LR_NOOP     = 3'd4
  } lres_e;

  typedef struct packed {
    logic data;
    logic pass_dirty;
    logic is_shared;
    logic was_unique;
  } snp_rsp_t;

  function automatic logic st_dirty(line_st_e s);
    return (s == ST_UD) || (s == ST_SD);
  endfunction

  function automatic logic st_unique(line_st_e s);
    return (s == ST_UC) || (s == ST_UD);
  endfunction

  function automatic line_st_e st_clean(line_st_e s);
    case (s)
      ST_UD:   return ST_UC;
      ST_SD:   return ST_SC;
      default: return s;
    endcase
  endfunction

  // State a line takes when its outstanding request completes.
  function automatic line_st_e cmp_next(req_e rq, line_st_e cur, logic sh,
                                        logic dt, logic owned);
    case (rq)
      RQ_RD_SHARED, RQ_RD_NSD: begin
        if (sh)      return (dt && owned) ? ST_SD : ST_SC;
        else if (dt) return ST_UD;
        else         return ST_UC;
      end
      RQ_MAKE_UNIQ, RQ_RD_UNIQ, RQ_CLN_UNIQ: return ST_UD;
      RQ_WR_BACK, RQ_EVICT:                  return ST_I;
      RQ_WR_CLEAN:                           return st_clean(cur);
      default:                               return cur;
    endcase
  endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [TAG_W-1:0] ra_tag,
  output line_st_e         ra_st,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [TAG_W-1:0] rb_tag,
  output line_st_e         rb_st,
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  logic [TAG_W-1:0] wa_tag,
  input  line_st_e         wa_st,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  line_st_e         wb_st
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  line_st_e         st_q  [LINES];

  assign ra_tag = tag_q[ra_idx];
  assign ra_st  = st_q[ra_idx];
  assign rb_tag = tag_q[rb_idx];
  assign rb_st  = st_q[rb_idx];

  // Tags: single write port, no reset, fits distributed RAM.
  always_ff @(posedge clk) begin
    if (wa_en) tag_q[wa_idx] <= wa_tag;
  end

  // States: port A (local / completion) overrides port B (snoop) on the same index.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else begin
      if (wb_en) st_q[wb_idx] <= wb_st;
      if (wa_en) st_q[wa_idx] <= wa_st;
    end
  end
endmodule

// File: rtl/coh_req_sel.sv
module coh_req_sel
  import coh_pkg::*;
#(
  parameter bit OWNED_EN = 1'b1
) (
  input  line_st_e st,
  input  logic     tag_match,
  input  lcl_op_e  op,
  output lres_e    res,
  output req_e     req,
  output line_st_e hit_st
);
  logic valid, hit, conf, uniq, dirty;

  always_comb begin
    valid  = (st != ST_I);
    hit    = valid && tag_match;
    conf   = valid && !tag_match;
    uniq   = st_unique(st);
    dirty  = st_dirty(st);
    res    = LR_NOOP;
    req    = RQ_NONE;
    hit_st = st;
    case (op)
      LOP_LOAD: begin
        if (hit)       res = LR_HIT;
        else if (conf) res = LR_CONFLICT;
        else begin
          res = LR_ISSUED;
          req = OWNED_EN ? RQ_RD_SHARED : RQ_RD_NSD;
        end
      end
      LOP_STORE_FULL: begin
        if (hit && uniq) begin
          res    = LR_HIT;
          hit_st = ST_UD;
        end else if (conf) res = LR_CONFLICT;
        else begin
          res = LR_ISSUED;
          req = RQ_MAKE_UNIQ;
        end
      end
      LOP_STORE_PART: begin
        if (hit && uniq) begin
          res    = LR_HIT;
          hit_st = ST_UD;
        end else if (conf) res = LR_CONFLICT;
        else begin
          res = LR_ISSUED;
          req = hit ? RQ_CLN_UNIQ : RQ_RD_UNIQ;
        end
      end
      LOP_EVICT: begin
        if (hit) begin
          res = LR_ISSUED;
          req = dirty ? RQ_WR_BACK : RQ_EVICT;
        end
      end
      LOP_CLEAN: begin
        if (hit && dirty) begin
          res = LR_ISSUED;
          req = RQ_WR_CLEAN;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
  import coh_pkg::*;
#(
  parameter bit OWNED_EN = 1'b1
) (
  input  line_st_e st,
  input  logic     tag_match,
  input  snp_e     snp,
  output snp_rsp_t rsp,
  output line_st_e nxt,
  output logic     upd
);
  logic hit, dirty;

  always_comb begin
    hit   = (st != ST_I) && tag_match;
    dirty = st_dirty(st);
    rsp   = '0;
    nxt   = st;
    upd   = 1'b0;
    if (hit) begin
      rsp.was_unique = st_unique(st);
      case (snp)
        SN_RD_ONCE: begin
          rsp.data      = 1'b1;
          rsp.is_shared = 1'b1;
        end
        SN_RD_SHARED: begin
          rsp.data      = 1'b1;
          rsp.is_shared = 1'b1;
          upd           = 1'b1;
          if (dirty && OWNED_EN) nxt = ST_SD;
          else begin
            nxt            = ST_SC;
            rsp.pass_dirty = dirty;
          end
        end
        SN_RD_UNIQ: begin
          rsp.data       = 1'b1;
          rsp.pass_dirty = dirty;
          nxt            = ST_I;
          upd            = 1'b1;
        end
        SN_CLN_SHARED: begin
          rsp.data       = dirty;
          rsp.pass_dirty = dirty;
          rsp.is_shared  = 1'b1;
          nxt            = st_clean(st);
          upd            = 1'b1;
        end
        SN_CLN_INV: begin
          rsp.data       = dirty;
          rsp.pass_dirty = dirty;
          nxt            = ST_I;
          upd            = 1'b1;
        end
        SN_MK_INV: begin
          nxt = ST_I;
          upd = 1'b1;
        end
        default: rsp = '0;
      endcase
    end
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 2,
  parameter bit OWNED_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lcl_valid,
  input  logic [2:0]        lcl_op,
  input  logic [ADDR_W-1:0] lcl_addr,
  output logic              lcl_ready,
  output logic              lcl_done,
  output logic [2:0]        lcl_res,
  output logic [2:0]        lcl_prev_state,
  output logic              req_valid,
  output logic [3:0]        req_type,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              cmp_valid,
  input  logic              cmp_shared,
  input  logic              cmp_dirty,
  input  logic              snp_valid,
  input  logic [2:0]        snp_type,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              rsp_valid,
  output logic              rsp_data,
  output logic              rsp_pass_dirty,
  output logic              rsp_is_shared,
  output logic              rsp_was_unique
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic             busy_q;
  req_e             pend_req_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic [TAG_W-1:0] pend_tag_q;

  logic [IDX_W-1:0] l_idx, s_idx, ra_idx;
  logic [TAG_W-1:0] l_tag, s_tag, ra_tag, rb_tag;
  line_st_e         ra_st, rb_st;
  logic             lcl_acc;

  lres_e    sel_res;
  req_e     sel_req;
  line_st_e sel_hit_st;

  snp_rsp_t sn_rsp;
  line_st_e sn_nxt;
  logic     sn_upd;

  logic             wa_en;
  logic [IDX_W-1:0] wa_idx;
  logic [TAG_W-1:0] wa_tag;
  line_st_e         wa_st;

  assign l_idx = lcl_addr[IDX_W-1:0];
  assign l_tag = lcl_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  assign lcl_ready = !busy_q && !snp_valid;
  assign lcl_acc   = lcl_valid && lcl_ready;
  assign ra_idx    = busy_q ? pend_idx_q : l_idx;

  coh_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .ra_idx (ra_idx),
    .ra_tag (ra_tag),
    .ra_st  (ra_st),
    .rb_idx (s_idx),
    .rb_tag (rb_tag),
    .rb_st  (rb_st),
    .wa_en  (wa_en),
    .wa_idx (wa_idx),
    .wa_tag (wa_tag),
    .wa_st  (wa_st),
    .wb_en  (snp_valid && sn_upd),
    .wb_idx (s_idx),
    .wb_st  (sn_nxt)
  );

  coh_req_sel #(.OWNED_EN(OWNED_EN)) u_sel (
    .st        (ra_st),
    .tag_match (ra_tag == l_tag),
    .op        (lcl_op_e'(lcl_op)),
    .res       (sel_res),
    .req       (sel_req),
    .hit_st    (sel_hit_st)
  );

  coh_snoop_resp #(.OWNED_EN(OWNED_EN)) u_snp (
    .st        (rb_st),
    .tag_match (rb_tag == s_tag),
    .snp       (snp_e'(snp_type)),
    .rsp       (sn_rsp),
    .nxt       (sn_nxt),
    .upd       (sn_upd)
  );

  // Port A: completion of the outstanding request, else a local hit update.
  always_comb begin
    wa_en  = 1'b0;
    wa_idx = l_idx;
    wa_tag = ra_tag;
    wa_st  = ra_st;
    if (busy_q && cmp_valid) begin
      wa_en  = 1'b1;
      wa_idx = pend_idx_q;
      wa_tag = pend_tag_q;
      wa_st  = cmp_next(pend_req_q, ra_st, cmp_shared, cmp_dirty, OWNED_EN);
    end else if (lcl_acc && sel_res == LR_HIT) begin
      wa_en = 1'b1;
      wa_st = sel_hit_st;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q         <= 1'b0;
      pend_req_q     <= RQ_NONE;
      pend_idx_q     <= '0;
      pend_tag_q     <= '0;
      lcl_done       <= 1'b0;
      lcl_res        <= LR_NONE;
      lcl_prev_state <= ST_I;
      req_valid      <= 1'b0;
      req_type       <= RQ_NONE;
      req_addr       <= '0;
      rsp_valid      <= 1'b0;
      rsp_data       <= 1'b0;
      rsp_pass_dirty <= 1'b0;
      rsp_is_shared  <= 1'b0;
      rsp_was_unique <= 1'b0;
    end else begin
      lcl_done  <= lcl_acc;
      lcl_res   <= lcl_acc ? sel_res : LR_NONE;
      req_valid <= lcl_acc && (sel_res == LR_ISSUED);
      if (lcl_acc) begin
        lcl_prev_state <= ra_st;
        req_type       <= sel_req;
        req_addr       <= lcl_addr;
      end
      if (lcl_acc && sel_res == LR_ISSUED) begin
        busy_q     <= 1'b1;
        pend_req_q <= sel_req;
        pend_idx_q <= l_idx;
        pend_tag_q <= l_tag;
      end else if (busy_q && cmp_valid) begin
        busy_q <= 1'b0;
      end
      rsp_valid      <= snp_valid;
      rsp_data       <= snp_valid && sn_rsp.data;
      rsp_pass_dirty <= snp_valid && sn_rsp.pass_dirty;
      rsp_is_shared  <= snp_valid && sn_rsp.is_shared;
      rsp_was_unique <= snp_valid && sn_rsp.was_unique;
    end
  end
endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk #(
  parameter bit OWNED_EN = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       lcl_valid,
  input logic       lcl_ready,
  input logic       lcl_done,
  input logic [2:0] lcl_res,
  input logic       req_valid,
  input logic [3:0] req_type,
  input logic       snp_valid,
  input logic [2:0] snp_type,
  input logic       rsp_valid,
  input logic       rsp_data,
  input logic       rsp_pass_dirty
);
  // R10
  rsp_follows_snp_chk: assert property (@(posedge clk) disable iff (rst)
    snp_valid |=> rsp_valid);
  // R10
  rsp_needs_snp_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(snp_valid));
  // R12
  mk_inv_no_data_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && snp_type == 3'd5) |=> (!rsp_data && !rsp_pass_dirty));
  // R11
  pass_dirty_with_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_pass_dirty) |-> rsp_data);
  // R9
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);
  // R9
  req_blocks_ready_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !lcl_ready);
  // R2
  req_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $past(lcl_valid && lcl_ready));
  // R4
  hit_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (lcl_done && lcl_res == 3'd1) |-> !req_valid);
  // R3
  nso_no_rd_shared_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_type == 4'd1) |-> OWNED_EN);
endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.OWNED_EN(OWNED_EN)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .lcl_valid      (lcl_valid),
  .lcl_ready      (lcl_ready),
  .lcl_done       (lcl_done),
  .lcl_res        (lcl_res),
  .req_valid      (req_valid),
  .req_type       (req_type),
  .snp_valid      (snp_valid),
  .snp_type       (snp_type),
  .rsp_valid      (rsp_valid),
  .rsp_data       (rsp_data),
  .rsp_pass_dirty (rsp_pass_dirty)
);

// File: tb/tb_coh_line_ctrl.sv
module tb_coh_line_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          lcl_valid = 1'b0;
  logic [2:0]    lcl_op = '0;
  logic [AW-1:0] lcl_addr = '0;
  logic          snp_valid = 1'b0;
  logic [2:0]    snp_type = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          cmp_shared = 1'b0;
  logic          cmp_dirty = 1'b0;
  logic          cmp_v [2];

  logic          lcl_ready_o [2];
  logic          lcl_done_o  [2];
  logic [2:0]    lcl_res_o   [2];
  logic [2:0]    lcl_prev_o  [2];
  logic          req_valid_o [2];
  logic [3:0]    req_type_o  [2];
  logic [AW-1:0] req_addr_o  [2];
  logic          rsp_valid_o [2];
  logic          rsp_data_o  [2];
  logic          rsp_pd_o    [2];
  logic          rsp_sh_o    [2];
  logic          rsp_wu_o    [2];

  coh_line_ctrl #(.ADDR_W(AW), .IDX_W(IW), .OWNED_EN(1'b1)) dut (
    .clk(clk), .rst(rst), .lcl_valid(lcl_valid), .lcl_op(lcl_op), .lcl_addr(lcl_addr),
    .lcl_ready(lcl_ready_o[0]), .lcl_done(lcl_done_o[0]), .lcl_res(lcl_res_o[0]),
    .lcl_prev_state(lcl_prev_o[0]), .req_valid(req_valid_o[0]), .req_type(req_type_o[0]),
    .req_addr(req_addr_o[0]), .cmp_valid(cmp_v[0]), .cmp_shared(cmp_shared),
    .cmp_dirty(cmp_dirty), .snp_valid(snp_valid), .snp_type(snp_type), .snp_addr(snp_addr),
    .rsp_valid(rsp_valid_o[0]), .rsp_data(rsp_data_o[0]), .rsp_pass_dirty(rsp_pd_o[0]),
    .rsp_is_shared(rsp_sh_o[0]), .rsp_was_unique(rsp_wu_o[0]));

  coh_line_ctrl #(.ADDR_W(AW), .IDX_W(IW), .OWNED_EN(1'b0)) dut_nso (
    .clk(clk), .rst(rst), .lcl_valid(lcl_valid), .lcl_op(lcl_op), .lcl_addr(lcl_addr),
    .lcl_ready(lcl_ready_o[1]), .lcl_done(lcl_done_o[1]), .lcl_res(lcl_res_o[1]),
    .lcl_prev_state(lcl_prev_o[1]), .req_valid(req_valid_o[1]), .req_type(req_type_o[1]),
    .req_addr(req_addr_o[1]), .cmp_valid(cmp_v[1]), .cmp_shared(cmp_shared),
    .cmp_dirty(cmp_dirty), .snp_valid(snp_valid), .snp_type(snp_type), .snp_addr(snp_addr),
    .rsp_valid(rsp_valid_o[1]), .rsp_data(rsp_data_o[1]), .rsp_pass_dirty(rsp_pd_o[1]),
    .rsp_is_shared(rsp_sh_o[1]), .rsp_was_unique(rsp_wu_o[1]));

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Bench model of the single index under test, one entry per copy.
  logic [2:0]    mst [2];
  logic [AW-IW-1:0] mtag = '0;

  localparam logic [AW-1:0] ADDR_A = {4'h5, 2'd1};
  localparam logic [AW-1:0] ADDR_B = {4'ha, 2'd1};

  task automatic check(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Returns {result[2:0], request[3:0]} from the requirement tables.
  function automatic logic [6:0] exp_loc(input bit owned, input logic [2:0] st,
                                         input bit tm, input logic [2:0] op);
    bit v, hit, conf, uniq, dirty;
    logic [2:0] r;
    logic [3:0] q;
    v = (st != 3'd0); hit = v && tm; conf = v && !tm;
    uniq = (st == 3'd1) || (st == 3'd2);
    dirty = (st == 3'd2) || (st == 3'd4);
    r = 3'd4; q = 4'd0;
    case (op)
      3'd0: if (hit) r = 3'd1; else if (conf) r = 3'd3;
            else begin r = 3'd2; q = owned ? 4'd1 : 4'd2; end
      3'd1: if (hit && uniq) r = 3'd1; else if (conf) r = 3'd3;
            else begin r = 3'd2; q = 4'd3; end
      3'd2: if (hit && uniq) r = 3'd1; else if (conf) r = 3'd3;
            else begin r = 3'd2; q = hit ? 4'd5 : 4'd4; end
      3'd3: if (hit) begin r = 3'd2; q = dirty ? 4'd6 : 4'd7; end
      3'd4: if (hit && dirty) begin r = 3'd2; q = 4'd8; end
      default: ;
    endcase
    return {r, q};
  endfunction

  function automatic logic [2:0] clean_of(input logic [2:0] st);
    if (st == 3'd2) return 3'd1;
    if (st == 3'd4) return 3'd3;
    return st;
  endfunction

  function automatic logic [2:0] exp_after(input bit owned, input logic [2:0] st,
      input logic [2:0] op, input logic [2:0] r, input logic [3:0] q,
      input bit csh, input bit cdt);
    if (r == 3'd1) return (op == 3'd1 || op == 3'd2) ? 3'd2 : st;
    if (r != 3'd2) return st;
    case (q)
      4'd1, 4'd2: return csh ? ((cdt && owned) ? 3'd4 : 3'd3) : (cdt ? 3'd2 : 3'd1);
      4'd3, 4'd4, 4'd5: return 3'd2;
      4'd6, 4'd7: return 3'd0;
      4'd8: return clean_of(st);
      default: return st;
    endcase
  endfunction

  // Returns {data, pass_dirty, is_shared, was_unique, next[2:0]}.
  function automatic logic [6:0] exp_snp(input bit owned, input logic [2:0] st,
                                         input bit tm, input logic [2:0] sn);
    bit wu, dirty;
    if (!(st != 3'd0 && tm)) return {4'b0000, st};
    wu = (st == 3'd1) || (st == 3'd2);
    dirty = (st == 3'd2) || (st == 3'd4);
    case (sn)
      3'd0: return {1'b1, 1'b0, 1'b1, wu, st};
      3'd1: if (dirty && owned) return {1'b1, 1'b0, 1'b1, wu, 3'd4};
            else return {1'b1, dirty, 1'b1, wu, 3'd3};
      3'd2: return {1'b1, dirty, 1'b0, wu, 3'd0};
      3'd3: return {dirty, dirty, 1'b1, wu, clean_of(st)};
      3'd4: return {dirty, dirty, 1'b0, wu, 3'd0};
      3'd5: return {1'b0, 1'b0, 1'b0, wu, 3'd0};
      default: return {4'b0000, st};
    endcase
  endfunction

  function automatic string loc_tag(input logic [2:0] op, input logic [2:0] r);
    if (r == 3'd3) return "R8";
    case (op)
      3'd0: return "R3";
      3'd1, 3'd2: return (r == 3'd1) ? "R4" : "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic string snp_tag(input logic [2:0] st, input bit tm, input logic [2:0] sn);
    if (!(st != 3'd0 && tm)) return "R10";
    if (sn <= 3'd1) return "R11";
    if (sn == 3'd3) return "R13";
    return "R12";
  endfunction

  task automatic do_local(input logic [2:0] op, input logic [AW-1:0] addr,
                          input bit csh, input bit cdt);
    bit tm;
    logic [6:0] e [2];
    tm = (addr[AW-1:IW] == mtag);
    @(negedge clk);
    lcl_valid = 1'b1; lcl_op = op; lcl_addr = addr;
    @(posedge clk);
    @(negedge clk);
    lcl_valid = 1'b0;
    for (int d = 0; d < 2; d++) begin
      e[d] = exp_loc(d == 0, mst[d], tm, op);
      check("R2", "lcl_done", int'(lcl_done_o[d]), 1);
      check("R2", "lcl_prev_state", int'(lcl_prev_o[d]), int'(mst[d]));
      check(loc_tag(op, e[d][6:4]), "lcl_res", int'(lcl_res_o[d]), int'(e[d][6:4]));
      check(loc_tag(op, e[d][6:4]), "req_valid", int'(req_valid_o[d]), int'(e[d][6:4] == 3'd2));
      if (e[d][6:4] == 3'd2) begin
        check(loc_tag(op, e[d][6:4]), "req_type", int'(req_type_o[d]), int'(e[d][3:0]));
        check("R9", "req_addr", int'(req_addr_o[d]), int'(addr));
        check("R9", "lcl_ready while pending", int'(lcl_ready_o[d]), 0);
      end
      cmp_v[d] = (e[d][6:4] == 3'd2);
    end
    cmp_shared = csh; cmp_dirty = cdt;
    @(posedge clk);
    @(negedge clk);
    cmp_v[0] = 1'b0; cmp_v[1] = 1'b0;
    for (int d = 0; d < 2; d++) begin
      logic [2:0] ns;
      ns = exp_after(d == 0, mst[d], op, e[d][6:4], e[d][3:0], csh, cdt);
      if ((e[d][6:4] == 3'd1 || e[d][6:4] == 3'd2) && ns != 3'd0) mtag = addr[AW-1:IW];
      mst[d] = ns;
      #1;
      check("R9", "lcl_ready after completion", int'(lcl_ready_o[d]), 1);
    end
  endtask

  task automatic do_snoop(input logic [2:0] sn, input logic [AW-1:0] addr);
    bit tm;
    logic [6:0] e;
    string t;
    tm = (addr[AW-1:IW] == mtag);
    @(negedge clk);
    snp_valid = 1'b1; snp_type = sn; snp_addr = addr;
    #1;
    for (int d = 0; d < 2; d++)
      check("R9", "lcl_ready during snoop", int'(lcl_ready_o[d]), 0);
    @(posedge clk);
    @(negedge clk);
    snp_valid = 1'b0;
    for (int d = 0; d < 2; d++) begin
      e = exp_snp(d == 0, mst[d], tm, sn);
      t = snp_tag(mst[d], tm, sn);
      check("R10", "rsp_valid", int'(rsp_valid_o[d]), 1);
      check(t, "rsp_data", int'(rsp_data_o[d]), int'(e[6]));
      check(t, "rsp_pass_dirty", int'(rsp_pd_o[d]), int'(e[5]));
      check(t, "rsp_is_shared", int'(rsp_sh_o[d]), int'(e[4]));
      check("R10", "rsp_was_unique", int'(rsp_wu_o[d]), int'(e[3]));
      mst[d] = e[2:0];
    end
    @(negedge clk);
    for (int d = 0; d < 2; d++)
      check("R10", "rsp_valid drops", int'(rsp_valid_o[d]), 0);
  endtask

  task automatic reach(input int s);
    case (s)
      1: do_local(3'd0, ADDR_A, 1'b0, 1'b0);
      2: do_local(3'd1, ADDR_A, 1'b0, 1'b0);
      3: do_local(3'd0, ADDR_A, 1'b1, 1'b0);
      4: do_local(3'd0, ADDR_A, 1'b1, 1'b1);
      default: ;
    endcase
  endtask

  task automatic clear_line();
    if (mst[0] != 3'd0 || mst[1] != 3'd0) do_local(3'd3, ADDR_A, 1'b0, 1'b0);
    if (mst[0] != 3'd0 || mst[1] != 3'd0) begin
      fails++;
      $display("FAIL R6 line not cleared: actual=%0d expected=0", mst[0]);
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cmp_v[0] = 1'b0; cmp_v[1] = 1'b0;
    mst[0] = 3'd0; mst[1] = 3'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      check("R1", "lcl_ready", int'(lcl_ready_o[d]), 1);
      check("R1", "lcl_done", int'(lcl_done_o[d]), 0);
      check("R1", "req_valid", int'(req_valid_o[d]), 0);
      check("R1", "rsp_valid", int'(rsp_valid_o[d]), 0);
    end
    // R1: probe a fresh line, reports Invalid.
    do_local(3'd4, ADDR_A, 1'b0, 1'b0);

    // Local event sweep: every start state by every event.
    for (int s = 0; s < 5; s++) begin
      for (int op = 0; op < 5; op++) begin
        reach(s);
        do_local(3'(op), ADDR_A, 1'b0, 1'b0);
        do_local(3'd0, ADDR_A, 1'b0, 1'b0);
        clear_line();
      end
    end

    // R3: load miss completion flag combinations.
    for (int f = 0; f < 4; f++) begin
      do_local(3'd0, ADDR_A, f[1], f[0]);
      do_local(3'd0, ADDR_A, 1'b0, 1'b0);
      clear_line();
    end

    // Snoop sweep: every start state by every snoop type.
    for (int s = 0; s < 5; s++) begin
      for (int sn = 0; sn < 6; sn++) begin
        reach(s);
        do_snoop(3'(sn), ADDR_A);
        do_local(3'd0, ADDR_A, 1'b0, 1'b0);
        clear_line();
      end
    end

    // R8 and R10: conflicting tag on the same index.
    reach(2);
    do_local(3'd0, ADDR_B, 1'b0, 1'b0);
    do_local(3'd2, ADDR_B, 1'b0, 1'b0);
    do_local(3'd3, ADDR_B, 1'b0, 1'b0);
    do_snoop(3'd4, ADDR_B);
    do_snoop(3'd0, ADDR_A);
    clear_line();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule